// File: doc/BRIEF.md
# Adaptive Standby Current Filter

This block holds the standby-current estimate of a battery monitor. Coming out of reset it reports a programmed default. After that it moves toward the measured average current through a first-order low-pass step. The step applies only on a sample tick, and only when the sample lies inside a qualifying window. Each step keeps fifteen sixteenths of the old estimate and adds one sixteenth of the new sample. At the usual tick period of about five seconds this gives a time constant of roughly a minute.

The window has two bounds. The lower bound is a programmable dead-band threshold that the sample must strictly exceed. The upper bound is twice the programmed default, and the block captures it once, on the first clock after reset. A later change to the programmed input therefore moves neither the bound nor the estimate. The estimate comes out as a high byte and a low byte for read-only host access. The full code is `256*hi + lo`. This block does not convert the code to milliamps.

Top module: `stby_cur_filter`

## Requirements
- R1: While reset is asserted, and on the first clock after reset is released, the output code equals `prog_sby_i`. On that first clock the block latches the value as its estimate and captures twice the value as the upper window bound.
- R2: With `tick_i` low, the output code never changes.
- R3: A tick whose `avg_cur_i` is less than or equal to `dmf_thr_i` leaves the code unchanged. A sample that is one LSB above the threshold is accepted.
- R4: A tick whose `avg_cur_i` exceeds twice the programmed value captured after reset leaves the code unchanged. A sample exactly equal to twice that value is accepted.
- R5: After the first clock following reset, changes to `prog_sby_i` do not affect the output code or the upper window bound.
- R6: An accepted tick sets the code, one clock later, to `old - (old >> 4) + (avg >> 4)`, computed on unsigned 16-bit values.
- R7: `si_hi_o` carries code bits 15..8 and `si_lo_o` carries code bits 7..0.
- R8: With a constant accepted sample, successive steps move the code monotonically toward the sample. The code never passes the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| prog_sby_i | input | 16 | Programmed default standby current code |
| avg_cur_i | input | 16 | Measured average current code |
| dmf_thr_i | input | 16 | Dead-band threshold that a sample must exceed |
| tick_i | input | 1 | One-clock sample-period strobe |
| si_hi_o | output | 8 | Estimate, high byte |
| si_lo_o | output | 8 | Estimate, low byte |

## Verification
The bench builds the block with its default 16-bit width and a shift of four. With these values the step is the fifteen-sixteenths filter, and the upper window bound needs a 17th bit. A second reset with an all-ones default pushes the bound to 0x1FFFE, so a full-scale sample must be accepted. A long run of identical samples brings the estimate into its truncation dead zone, where the step stops moving the code, and this exposes any overshoot.

// File: rtl/stby_pkg.sv
package stby_pkg;
  // Phase of the estimator: seed from the programmed default, then filter.
  typedef enum logic {
    PH_SEED = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/stby_win_qual.sv
module stby_win_qual #(
  parameter int DATA_W = 16
) (
  input  logic              tick_i,
  input  logic              run_i,
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] thr_i,
  input  logic [DATA_W:0]   lim_i,
  output logic              take_o
);
  logic above_thr;
  logic under_lim;

  always_comb begin
    above_thr = (cur_i > thr_i);
    under_lim = ({1'b0, cur_i} <= lim_i);
    take_o    = tick_i & run_i & above_thr & under_lim;
  end
endmodule

// File: rtl/stby_iir_step.sv
module stby_iir_step #(
  parameter int DATA_W = 16,
  parameter int SHIFT  = 4
) (
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] cur_i,
  output logic [DATA_W-1:0] new_o
);
  generate
    if (SHIFT == 0) begin : g_pass
      always_comb new_o = cur_i;
    end else begin : g_leak
      // old - old/2^S + cur/2^S never exceeds the larger operand, so no carry out.
      logic [DATA_W-1:0] old_part;
      logic [DATA_W-1:0] cur_part;
      always_comb begin
        old_part = old_i >> SHIFT;
        cur_part = cur_i >> SHIFT;
        new_o    = old_i - old_part + cur_part;
      end
    end
  endgenerate
endmodule

// File: rtl/stby_cur_filter.sv
module stby_cur_filter #(
  parameter int DATA_W = 16,
  parameter int SHIFT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] prog_sby_i,
  input  logic [DATA_W-1:0] avg_cur_i,
  input  logic [DATA_W-1:0] dmf_thr_i,
  input  logic              tick_i,
  output logic [DATA_W-9:0] si_hi_o,
  output logic [7:0]        si_lo_o
);
  import stby_pkg::*;

  localparam int LIM_W = DATA_W + 1;

  phase_e            phase_q, phase_d;
  logic [DATA_W-1:0] si_q, si_d;
  logic [LIM_W-1:0]  lim_q, lim_d;
  logic              run_w;
  logic              take_w;
  logic [DATA_W-1:0] step_w;
  logic [DATA_W-1:0] code_w;

  assign run_w = (phase_q == PH_RUN);

  stby_win_qual #(.DATA_W(DATA_W)) qual_i (
    .tick_i (tick_i),
    .run_i  (run_w),
    .cur_i  (avg_cur_i),
    .thr_i  (dmf_thr_i),
    .lim_i  (lim_q),
    .take_o (take_w)
  );

  stby_iir_step #(.DATA_W(DATA_W), .SHIFT(SHIFT)) step_i (
    .old_i (si_q),
    .cur_i (avg_cur_i),
    .new_o (step_w)
  );

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    si_d    = si_q;
    lim_d   = lim_q;
    if (!run_w) begin
      phase_d = PH_RUN;
      si_d    = prog_sby_i;
      lim_d   = {prog_sby_i, 1'b0};
    end else if (take_w) begin
      si_d    = step_w;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SEED;
      si_q    <= '0;
      lim_q   <= '0;
    end else begin
      phase_q <= phase_d;
      si_q    <= si_d;
      lim_q   <= lim_d;
    end
  end

  // Until seeded, the programmed default is shown directly.
  always_comb begin
    code_w  = run_w ? si_q : prog_sby_i;
    si_hi_o = code_w[DATA_W-1:8];
    si_lo_o = code_w[7:0];
  end
endmodule

// File: rtl/stby_cur_filter_chk.sv
module stby_cur_filter_chk #(
  parameter int DATA_W = 16,
  parameter int SHIFT  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_w,
  input logic [DATA_W:0]   lim_q,
  input logic [DATA_W-1:0] prog_sby_i,
  input logic [DATA_W-1:0] avg_cur_i,
  input logic [DATA_W-1:0] dmf_thr_i,
  input logic              tick_i,
  input logic [DATA_W-9:0] si_hi_o,
  input logic [7:0]        si_lo_o
);
  logic [DATA_W-1:0] code;
  logic              ok_win;
  assign code   = {si_hi_o, si_lo_o};
  assign ok_win = run_w && tick_i && (avg_cur_i > dmf_thr_i) && ({1'b0, avg_cur_i} <= lim_q);

  // R1: before seeding the output tracks the programmed default
  assert_seed_shows_prog_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w |-> code == prog_sby_i);

  assert_seed_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w |=> (lim_q == {$past(prog_sby_i), 1'b0}) && (code == $past(prog_sby_i)));

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_w && !tick_i |=> $stable(code));

  assert_dmf_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_w && tick_i && (avg_cur_i <= dmf_thr_i) |=> $stable(code));

  assert_limit_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_w && tick_i && ({1'b0, avg_cur_i} > lim_q) |=> $stable(code));

  assert_limit_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_w |=> $stable(lim_q));

  assert_step_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ok_win |=> code == DATA_W'($past(code) - ($past(code) >> SHIFT) + ($past(avg_cur_i) >> SHIFT)));

  assert_rise_toward_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ok_win && (code <= avg_cur_i) |=> (code >= $past(code)) && (code <= $past(avg_cur_i)));

  assert_fall_toward_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ok_win && (code > avg_cur_i) |=> (code <= $past(code)) && (code >= $past(avg_cur_i)));
endmodule

bind stby_cur_filter stby_cur_filter_chk #(.DATA_W(DATA_W), .SHIFT(SHIFT)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_w      (run_w),
  .lim_q      (lim_q),
  .prog_sby_i (prog_sby_i),
  .avg_cur_i  (avg_cur_i),
  .dmf_thr_i  (dmf_thr_i),
  .tick_i     (tick_i),
  .si_hi_o    (si_hi_o),
  .si_lo_o    (si_lo_o)
);

// File: tb/stby_cur_filter_tb_top.sv
`timescale 1ns/1ps
module stby_cur_filter_tb_top;
  logic        clk;
  logic        rst_n;
  logic [15:0] prog_sby;
  logic [15:0] avg_cur;
  logic [15:0] dmf_thr;
  logic        tick;
  logic [7:0]  si_hi;
  logic [7:0]  si_lo;

  int n_chk;
  int n_err;
  logic [15:0] exp_si;
  logic [16:0] exp_lim;

  stby_cur_filter #(.DATA_W(16), .SHIFT(4)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_sby_i (prog_sby),
    .avg_cur_i  (avg_cur),
    .dmf_thr_i  (dmf_thr),
    .tick_i     (tick),
    .si_hi_o    (si_hi),
    .si_lo_o    (si_lo)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_step(input logic [15:0] old, input logic [15:0] cur);
    return old - (old >> 4) + (cur >> 4);
  endfunction

  // Apply one tick and update the model when the sample lies in the window.
  task automatic do_tick(input logic [15:0] cur);
    @(negedge clk);
    avg_cur = cur;
    tick    = 1'b1;
    @(negedge clk);
    tick    = 1'b0;
    if (cur > dmf_thr && {1'b0, cur} <= exp_lim) exp_si = model_step(exp_si, cur);
  endtask

  task automatic do_reset(input logic [15:0] prog);
    @(negedge clk);
    rst_n    = 1'b0;
    prog_sby = prog;
    tick     = 1'b0;
    #1;
    check("R1 in reset", {si_hi, si_lo}, prog);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_si  = prog;
    exp_lim = {prog, 1'b0};
    check("R1 seeded", {si_hi, si_lo}, prog);
  endtask

  task automatic t_no_tick();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      avg_cur = 16'(300 + i * 97);
    end
    @(negedge clk);
    check("R2 no tick", {si_hi, si_lo}, exp_si);
  endtask

  task automatic t_dmf();
    do_tick(dmf_thr);
    check("R3 at threshold ignored", {si_hi, si_lo}, exp_si);
    do_tick(16'd10);
    check("R3 below threshold ignored", {si_hi, si_lo}, exp_si);
    do_tick(dmf_thr + 16'd1);
    check("R3 one above accepted (R6 step)", {si_hi, si_lo}, exp_si);
  endtask

  task automatic t_limit();
    do_tick(16'(exp_lim + 17'd1));
    check("R4 above limit ignored", {si_hi, si_lo}, exp_si);
    do_tick(16'(exp_lim));
    check("R4 at limit accepted (R6 step)", {si_hi, si_lo}, exp_si);
  endtask

  task automatic t_prog_change();
    @(negedge clk);
    prog_sby = 16'h0100;
    @(negedge clk);
    check("R5 prog change no effect", {si_hi, si_lo}, exp_si);
    do_tick(16'd1500);
    check("R5 limit kept from seed", {si_hi, si_lo}, exp_si);
  endtask

  task automatic t_bytes();
    do_tick(16'd1234);
    check("R7 high byte", {8'h00, si_hi}, {8'h00, exp_si[15:8]});
    check("R7 low byte", {8'h00, si_lo}, {8'h00, exp_si[7:0]});
  endtask

  task automatic t_converge(input logic [15:0] target);
    logic [15:0] prev;
    logic        mono_bad;
    logic        model_bad;
    logic        rising;
    mono_bad  = 1'b0;
    model_bad = 1'b0;
    prev      = {si_hi, si_lo};
    rising    = (prev <= target);
    for (int i = 0; i < 200; i++) begin
      do_tick(target);
      if ({si_hi, si_lo} !== exp_si) model_bad = 1'b1;
      if (rising && ({si_hi, si_lo} < prev || {si_hi, si_lo} > target)) mono_bad = 1'b1;
      if (!rising && ({si_hi, si_lo} > prev || {si_hi, si_lo} < target)) mono_bad = 1'b1;
      prev = {si_hi, si_lo};
    end
    check("R6 step sequence matches", {15'd0, model_bad}, 16'd0);
    check("R8 monotone no overshoot", {15'd0, mono_bad}, 16'd0);
    check("R8 settled near target", {15'd0, ((target - prev) <= 16'd15 || (prev - target) <= 16'd15)}, 16'd1);
  endtask

  task automatic t_full_scale();
    do_reset(16'hFFFF);
    do_tick(16'hFFFF);
    check("R4 full-scale at limit accepted", {si_hi, si_lo}, 16'hFFFF);
    do_tick(16'h0800);
    check("R6 step down from full scale", {si_hi, si_lo}, exp_si);
  endtask

  initial begin
    n_chk    = 0;
    n_err    = 0;
    rst_n    = 1'b0;
    tick     = 1'b0;
    prog_sby = 16'h0400;
    avg_cur  = 16'h0000;
    dmf_thr  = 16'h0040;
    exp_si   = 16'h0400;
    exp_lim  = 17'h00800;
    repeat (2) @(negedge clk);
    do_reset(16'h0400);
    t_no_tick();
    t_dmf();
    t_limit();
    t_prog_change();
    t_bytes();
    t_converge(16'd1500);
    t_converge(16'd200);
    t_full_scale();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule